// File: doc/BRIEF.md
# DMA Transfer Mode Selector

This block chooses the fastest DMA transfer mode that both a drive and its host controller can use. It runs once per request. A controller presents the drive's capability bytes, taken from its identify data, together with the host's supported-mode masks, a cable-detect bit and an upper-limit mode code. It then pulses `start`. The block keeps a copy of all inputs on that edge. It then visits three mode classes in a fixed order: Ultra DMA first, then multiword DMA, then single-word DMA. It stops at the first class that leaves a usable mode.

Within a class, the candidate mask is the host mask ANDed with the device's mode byte. Two special rules apply. The Ultra mask is clipped when no 80-wire cable is present. When the device's capability words are flagged invalid, a single-word mask is built from a legacy timing mode. The highest set bit gives the mode index. The mode code is the class base plus that index, limited to the requested code. The result and a "no DMA" flag are registered and stay on the outputs until the next request completes.

The controller runs as five named states:
- `S_IDLE` waits for `start`. From there, `start` goes to `S_UDMA`, or straight to `S_DONE` when a packet device sits on a host that forbids packet DMA.
- `S_UDMA`, `S_MWDMA` and `S_SWDMA` each evaluate one class in one cycle. A hit goes to `S_DONE`. A miss goes to the next class.
- `S_SWDMA` always goes on to `S_DONE`.
- `S_DONE` raises `done` for one cycle and returns to `S_IDLE`.

Top module: `dma_mode_select`

## Requirements
- R1: After reset, `busy` and `done` are 0, `mode_o` is 0x00 and `no_dma` is 1.
- R2: A `start` sampled in `S_IDLE` raises `busy` from the next cycle until `done` inclusive, and `done` is a one-cycle pulse. Measured from the cycle in which `start` is high, `done` appears after:
  - 1 cycle for a packet-blocked request,
  - 2 cycles when Ultra DMA is chosen,
  - 3 cycles when multiword DMA is chosen,
  - 4 cycles otherwise (single-word chosen or nothing found).
- R3: `start` while `busy` is ignored. Input changes after the accepted `start` do not affect the result.
- R4: Classes are tried in the order Ultra (base 0x40), multiword (base 0x20), single-word (base 0x10). A class whose base exceeds `req_mode` is skipped but still takes its cycle.
- R5: Ultra is considered only when `udma_word_ok` is 1. The multiword byte and the single-word byte are used only when `dma_words_ok` is 1.
- R6: The class mask is the host mask AND the device byte, where bit i means mode i. The chosen code is the class base plus the index of the highest set bit.
- R7: If `req_mode` > 0x42, the Ultra mask has any of bits 3..6 set, and `cable_80w` is 0, the Ultra mask is cut to bits 0..2. A mask with bit 7 but none of bits 3..6 is not cut.
- R8: When `dma_words_ok` is 0 and `legacy_sw_timing` m is 1 or 2, the single-word mask is ((2<<m)-1) AND `host_swdma_mask`. Any other m gives an empty mask.
- R9: The reported code is the smaller of the chosen code and `req_mode`.
- R10: When `is_packet_dev` and `host_no_packet_dma` are both 1, the result is 0x00 with `no_dma` = 1.
- R11: If no class yields a set bit, `mode_o` is 0x00 and `no_dma` is 1. Otherwise `no_dma` is 0.
- R12: `mode_o` and `no_dma` change only in the cycle where `done` is high, and hold between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a selection (accepted only when idle) |
| is_packet_dev | input | 1 | Drive is a packet (non-disk) device |
| host_no_packet_dma | input | 1 | Host forbids DMA for packet devices |
| udma_word_ok | input | 1 | Identify Ultra word is valid |
| dma_words_ok | input | 1 | Identify multiword/single-word words are valid |
| dev_udma_modes | input | MASK_W | Device Ultra modes supported, bit i = mode i |
| dev_mwdma_modes | input | MASK_W | Device multiword modes supported |
| dev_swdma_modes | input | MASK_W | Device single-word modes supported |
| legacy_sw_timing | input | CODE_W | Legacy single-word timing mode number |
| host_udma_mask | input | MASK_W | Host Ultra modes supported |
| host_mwdma_mask | input | MASK_W | Host multiword modes supported |
| host_swdma_mask | input | MASK_W | Host single-word modes supported |
| cable_80w | input | 1 | 80-wire cable detected |
| req_mode | input | CODE_W | Highest mode code allowed |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle completion pulse |
| mode_o | output | CODE_W | Selected mode code (0x00 = none) |
| no_dma | output | 1 | No DMA mode usable |

## Verification
Each result is due a fixed number of cycles after its `start` cycle:
- one cycle for a packet-blocked request,
- two cycles when Ultra wins,
- three cycles when multiword wins,
- four cycles otherwise.

The bench drives inputs on the falling edge and counts falling edges until `done`. It compares that count with the latency its reference model predicts from the same class walk. It checks `mode_o` and `no_dma` on the cycle `done` is seen, and checks one cycle later that `done` has dropped while the outputs still hold. Requests that pulse `start` mid-selection with new inputs show whether the accepted snapshot decides the result.

// File: rtl/dma_mode_pkg.sv
package dma_mode_pkg;

    localparam int NUM_CLASSES = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_UDMA,
        S_MWDMA,
        S_SWDMA,
        S_DONE
    } sel_state_e;

    // Class index 0 = Ultra, 1 = multiword, 2 = single-word (search order).
    function automatic logic [7:0] class_base(input int cls);
        case (cls)
            0:       return 8'h40;
            1:       return 8'h20;
            default: return 8'h10;
        endcase
    endfunction

endpackage

// File: rtl/dma_mask_build.sv
module dma_mask_build
    import dma_mode_pkg::*;
#(
    parameter int MASK_W        = 8,
    parameter int CODE_W        = 8,
    parameter int UDMA_KEEP_TOP = 2
) (
    input  logic                                udma_ok,
    input  logic                                words_ok,
    input  logic [MASK_W-1:0]                   dev_u,
    input  logic [MASK_W-1:0]                   dev_m,
    input  logic [MASK_W-1:0]                   dev_s,
    input  logic [MASK_W-1:0]                   host_u,
    input  logic [MASK_W-1:0]                   host_m,
    input  logic [MASK_W-1:0]                   host_s,
    input  logic [CODE_W-1:0]                   legacy,
    input  logic                                cable80,
    input  logic [CODE_W-1:0]                   req,
    output logic [NUM_CLASSES-1:0][MASK_W-1:0]  masks,
    output logic [NUM_CLASSES-1:0]              eligible
);

    localparam int LEGACY_MAX = 2;

    logic [MASK_W-1:0] clip_hi;
    logic [MASK_W-1:0] keep_lo;
    logic [MASK_W-1:0] legacy_mask;
    logic [MASK_W-1:0] u_raw;
    logic              legacy_ok;

    always_comb begin
        clip_hi     = '0;
        keep_lo     = '0;
        legacy_mask = '0;
        for (int i = 0; i < MASK_W; i++) begin
            keep_lo[i]     = (i <= UDMA_KEEP_TOP);
            clip_hi[i]     = (i > UDMA_KEEP_TOP) && (i < MASK_W - 1);
            legacy_mask[i] = (32'(i) <= 32'(legacy));
        end
    end

    assign legacy_ok = (legacy != '0) && (32'(legacy) <= LEGACY_MAX);
    assign u_raw     = host_u & dev_u;

    always_comb begin
        if (!udma_ok) begin
            masks[0] = '0;
        end else if ((32'(req) > 32'(class_base(0)) + UDMA_KEEP_TOP)
                     && ((u_raw & clip_hi) != '0) && !cable80) begin
            masks[0] = u_raw & keep_lo;
        end else begin
            masks[0] = u_raw;
        end

        masks[1] = words_ok ? (host_m & dev_m) : '0;

        if (words_ok)       masks[2] = host_s & dev_s;
        else if (legacy_ok) masks[2] = legacy_mask & host_s;
        else                masks[2] = '0;
    end

    generate
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_elig
            assign eligible[c] = (32'(req) >= 32'(class_base(c)));
        end
    endgenerate

endmodule

// File: rtl/dma_msb_find.sv
module dma_msb_find #(
    parameter int MASK_W = 8,
    parameter int IDX_W  = $clog2(MASK_W)
) (
    input  logic [MASK_W-1:0] mask,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);

    always_comb begin
        idx = '0;
        for (int i = 0; i < MASK_W; i++) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end

    assign found = |mask;

endmodule

// File: rtl/dma_mode_select.sv
module dma_mode_select
    import dma_mode_pkg::*;
#(
    parameter int MASK_W        = 8,
    parameter int CODE_W        = 8,
    parameter int UDMA_KEEP_TOP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_packet_dev,
    input  logic              host_no_packet_dma,
    input  logic              udma_word_ok,
    input  logic              dma_words_ok,
    input  logic [MASK_W-1:0] dev_udma_modes,
    input  logic [MASK_W-1:0] dev_mwdma_modes,
    input  logic [MASK_W-1:0] dev_swdma_modes,
    input  logic [CODE_W-1:0] legacy_sw_timing,
    input  logic [MASK_W-1:0] host_udma_mask,
    input  logic [MASK_W-1:0] host_mwdma_mask,
    input  logic [MASK_W-1:0] host_swdma_mask,
    input  logic              cable_80w,
    input  logic [CODE_W-1:0] req_mode,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] mode_o,
    output logic              no_dma
);

    localparam int IDX_W = $clog2(MASK_W);

    typedef struct packed {
        logic              udma_ok;
        logic              words_ok;
        logic [MASK_W-1:0] dev_u;
        logic [MASK_W-1:0] dev_m;
        logic [MASK_W-1:0] dev_s;
        logic [MASK_W-1:0] host_u;
        logic [MASK_W-1:0] host_m;
        logic [MASK_W-1:0] host_s;
        logic [CODE_W-1:0] legacy;
        logic              cable80;
        logic [CODE_W-1:0] req;
    } snap_t;

    sel_state_e  state_q, state_d;
    snap_t       snap_q;
    logic [CODE_W-1:0] res_mode_q;
    logic              res_none_q;

    logic [NUM_CLASSES-1:0][MASK_W-1:0] masks;
    logic [NUM_CLASSES-1:0]             eligible;
    logic [NUM_CLASSES-1:0]             found;
    logic [NUM_CLASSES-1:0][IDX_W-1:0]  idx;

    logic              blocked;
    logic              in_check;
    int                cls;
    logic              hit;
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] capped;

    dma_mask_build #(
        .MASK_W        (MASK_W),
        .CODE_W        (CODE_W),
        .UDMA_KEEP_TOP (UDMA_KEEP_TOP)
    ) u_masks (
        .udma_ok  (snap_q.udma_ok),
        .words_ok (snap_q.words_ok),
        .dev_u    (snap_q.dev_u),
        .dev_m    (snap_q.dev_m),
        .dev_s    (snap_q.dev_s),
        .host_u   (snap_q.host_u),
        .host_m   (snap_q.host_m),
        .host_s   (snap_q.host_s),
        .legacy   (snap_q.legacy),
        .cable80  (snap_q.cable80),
        .req      (snap_q.req),
        .masks    (masks),
        .eligible (eligible)
    );

    generate
        for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_find
            dma_msb_find #(.MASK_W(MASK_W), .IDX_W(IDX_W)) u_find (
                .mask  (masks[c]),
                .found (found[c]),
                .idx   (idx[c])
            );
        end
    endgenerate

    assign blocked = is_packet_dev && host_no_packet_dma;

    // Class evaluated in the current state.
    always_comb begin
        in_check = 1'b1;
        cls      = 0;
        unique case (state_q)
            S_UDMA:  cls = 0;
            S_MWDMA: cls = 1;
            S_SWDMA: cls = 2;
            default: in_check = 1'b0;
        endcase
        hit    = in_check && eligible[cls] && found[cls];
        code   = CODE_W'(class_base(cls)) + CODE_W'(idx[cls]);
        capped = (code < snap_q.req) ? code : snap_q.req;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = blocked ? S_DONE : S_UDMA;
            S_UDMA:  state_d = hit ? S_DONE : S_MWDMA;
            S_MWDMA: state_d = hit ? S_DONE : S_SWDMA;
            S_SWDMA: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State, snapshot and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            snap_q     <= '0;
            res_mode_q <= '0;
            res_none_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start) begin
                snap_q <= '{udma_ok:  udma_word_ok,
                            words_ok: dma_words_ok,
                            dev_u:    dev_udma_modes,
                            dev_m:    dev_mwdma_modes,
                            dev_s:    dev_swdma_modes,
                            host_u:   host_udma_mask,
                            host_m:   host_mwdma_mask,
                            host_s:   host_swdma_mask,
                            legacy:   legacy_sw_timing,
                            cable80:  cable_80w,
                            req:      req_mode};
                if (blocked) begin
                    res_mode_q <= '0;
                    res_none_q <= 1'b1;
                end
            end else if (hit) begin
                res_mode_q <= capped;
                res_none_q <= 1'b0;
            end else if (state_q == S_SWDMA) begin
                res_mode_q <= '0;
                res_none_q <= 1'b1;
            end
        end
    end

    // Outputs.
    always_comb begin
        busy   = (state_q != S_IDLE);
        done   = (state_q == S_DONE);
        mode_o = res_mode_q;
        no_dma = res_none_q;
    end

endmodule

// File: rtl/dma_mode_select_chk.sv
module dma_mode_select_chk #(
    parameter int MASK_W = 8,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              is_packet_dev,
    input logic              host_no_packet_dma,
    input logic [CODE_W-1:0] req_mode,
    input logic              busy,
    input logic              done,
    input logic [CODE_W-1:0] mode_o,
    input logic              no_dma
);

    logic [CODE_W-1:0] req_cap;
    logic              blk_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_cap <= '0;
            blk_cap <= 1'b0;
        end else if (start && !busy) begin
            req_cap <= req_mode;
            blk_cap <= is_packet_dev && host_no_packet_dma;
        end
    end

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r3_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r9_capped_by_req: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_o <= req_cap));

    a_r10_packet_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (done && blk_cap) |-> no_dma);

    a_r11_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (no_dma == (mode_o == '0)));

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> done);

    a_r6_index_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_dma) |-> (32'(mode_o[3:0]) < MASK_W));

endmodule

bind dma_mode_select dma_mode_select_chk #(.MASK_W(MASK_W), .CODE_W(CODE_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .start              (start),
    .is_packet_dev      (is_packet_dev),
    .host_no_packet_dma (host_no_packet_dma),
    .req_mode           (req_mode),
    .busy               (busy),
    .done               (done),
    .mode_o             (mode_o),
    .no_dma             (no_dma)
);

// File: tb/test_dma_mode_select.sv
module test_dma_mode_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       pkt = 1'b0, nopkt = 1'b0, ok_u = 1'b0, ok_d = 1'b0, cable = 1'b0;
    logic [7:0] dev_u = '0, dev_m = '0, dev_s = '0;
    logic [7:0] host_u = '0, host_m = '0, host_s = '0;
    logic [7:0] legacy = '0, req = '0;
    logic       busy, done, no_dma;
    logic [7:0] mode_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5ns clk = ~clk;

    dma_mode_select i_dma_mode_select (
        .clk(clk), .rst_n(rst_n), .start(start),
        .is_packet_dev(pkt), .host_no_packet_dma(nopkt),
        .udma_word_ok(ok_u), .dma_words_ok(ok_d),
        .dev_udma_modes(dev_u), .dev_mwdma_modes(dev_m), .dev_swdma_modes(dev_s),
        .legacy_sw_timing(legacy),
        .host_udma_mask(host_u), .host_mwdma_mask(host_m), .host_swdma_mask(host_s),
        .cable_80w(cable), .req_mode(req),
        .busy(busy), .done(done), .mode_o(mode_o), .no_dma(no_dma)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int top_bit(input logic [7:0] m);
        int r = -1;
        for (int i = 0; i < 8; i++) if (m[i]) r = i;
        return r;
    endfunction

    // Reference model: returns {latency, mode}.
    function automatic int model(output int lat);
        logic [7:0] m;
        int b, k, code;
        if (pkt && nopkt) begin lat = 1; return 0; end
        for (int c = 0; c < 3; c++) begin
            b = (c == 0) ? 'h40 : (c == 1) ? 'h20 : 'h10;
            if (int'(req) >= b) begin
                if (c == 0) begin
                    m = ok_u ? (host_u & dev_u) : 8'h00;
                    if (int'(req) > 'h42 && (m & 8'h78) != 0 && !cable) m = m & 8'h07;
                end else if (c == 1) begin
                    m = ok_d ? (host_m & dev_m) : 8'h00;
                end else if (ok_d) begin
                    m = host_s & dev_s;
                end else if (legacy >= 1 && legacy <= 2) begin
                    m = 8'((2 << legacy) - 1) & host_s;
                end else begin
                    m = 8'h00;
                end
                k = top_bit(m);
                if (k >= 0) begin
                    code = b + k;
                    lat = 2 + c;
                    return (code < int'(req)) ? code : int'(req);
                end
            end
        end
        lat = 4;
        return 0;
    endfunction

    task automatic scramble();
        pkt = 1'($urandom); nopkt = 1'($urandom);
        ok_u = 1'($urandom); ok_d = 1'($urandom); cable = 1'($urandom);
        dev_u = 8'($urandom); dev_m = 8'($urandom); dev_s = 8'($urandom);
        host_u = 8'($urandom); host_m = 8'($urandom); host_s = 8'($urandom);
        legacy = 8'($urandom_range(0, 3));
        case ($urandom_range(0, 5))
            0: req = 8'h47;
            1: req = 8'h43;
            2: req = 8'h42;
            3: req = 8'($urandom_range(8'h20, 8'h27));
            4: req = 8'($urandom_range(8'h08, 8'h17));
            default: req = 8'($urandom);
        endcase
    endtask

    // Runs one request. poke: pulse start with new inputs while busy (R3).
    task automatic run_req(input string tag, input bit poke);
        int exp_mode, exp_lat, lat;
        exp_mode = model(exp_lat);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
        if (poke && !done) begin
            scramble();
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat = 2;
        end
        while (done !== 1'b1 && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        check(lat == exp_lat, poke ? "R3" : "R2", "latency", lat, exp_lat);
        check(mode_o === 8'(exp_mode), tag, "mode", int'(mode_o), exp_mode);
        check(no_dma === (exp_mode == 0), "R11", "no_dma", int'(no_dma), int'(exp_mode == 0));
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R2", "done/busy drop", {done, busy}, 0);
        check(mode_o === 8'(exp_mode), "R12", "mode held", int'(mode_o), exp_mode);
    endtask

    task automatic base_setup();
        pkt = 0; nopkt = 0; ok_u = 1; ok_d = 1; cable = 1;
        dev_u = 8'h7F; host_u = 8'h7F; dev_m = 8'h07; host_m = 8'h07;
        dev_s = 8'h07; host_s = 8'h07; legacy = 0; req = 8'h46;
    endtask

    initial begin
        #3ms;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy === 0 && done === 0, "R1", "busy/done", {busy, done}, 0);
        check(mode_o === 8'h00, "R1", "mode", int'(mode_o), 0);
        check(no_dma === 1'b1, "R1", "no_dma", int'(no_dma), 1);
        rst_n = 1'b1;
        @(negedge clk);

        base_setup();            run_req("R6", 0);          // 0x46
        req = 8'h44;             run_req("R9", 0);          // capped 0x44
        cable = 0; req = 8'h46;  run_req("R7", 0);          // clipped 0x42
        req = 8'h42;             run_req("R7", 0);          // no clip rule at 0x42
        dev_u = 8'h84; host_u = 8'hFF; req = 8'h47;
                                 run_req("R7", 0);          // bit 7 alone: 0x47
        base_setup(); ok_u = 0;  run_req("R5", 0);          // multiword 0x22
        base_setup(); req = 8'h22; run_req("R4", 0);        // Ultra skipped, 0x22
        base_setup(); ok_u = 0; ok_d = 0; legacy = 2;
                                 run_req("R8", 0);          // 0x12
        legacy = 1; host_s = 8'h01; run_req("R8", 0);       // 0x10
        legacy = 3; host_s = 8'hFF; run_req("R8", 0);       // none
        legacy = 0;              run_req("R11", 0);         // none
        base_setup(); pkt = 1; nopkt = 1; run_req("R10", 0);
        nopkt = 0;               run_req("R10", 0);         // allowed: 0x46
        base_setup(); req = 8'h0C; run_req("R4", 0);        // below all bases
        base_setup(); ok_u = 0; dev_m = 8'h00; ok_d = 1; req = 8'h25;
                                 run_req("R4", 0);          // falls to single-word 0x12
        base_setup();            run_req("R3", 1);
        base_setup(); ok_u = 0; ok_d = 0; legacy = 2; run_req("R3", 1);

        for (int n = 0; n < 300; n++) begin
            scramble();
            run_req("R6", (n % 5) == 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule